// File: doc/BRIEF.md
# Error-Detecting Latch Bank with Dual-Rail Error Collection

This block is a cycle-level model of a row of datapath latches. Some of these latches also watch for timing errors. While the latch enable is high, a latch is transparent and its output takes the data input at each clock edge. The first edge of an enable period opens the window and loads the new token. After that, if a monitored data bit changes on a later edge while the window is still open, the block treats it as a late arrival and sets that latch's sticky error flag. Latches that borrow time have no monitoring and can never raise a flag.

The flags are gathered in two stages. First, small groups of latches each feed one holding gate, which acts as an asymmetric C-element. Then several of these gates are ORed into one sampler. A controller asks for the verdict by raising `sample`. One cycle later the block answers on two rails: `err_hit` means at least one monitored latch saw a late change, and `err_clean` means none did. Both rails are low whenever no sample is pending. When the enable falls, the window closes and all flags and group gates clear, so the next token starts clean.

Top module: `edl_bank`

## Requirements
- R1: After reset, `q` is all zeros and `err_hit` and `err_clean` are both low.
- R2: `q` takes `d` at every clock edge where `lat_en` is high, and holds its value at every edge where `lat_en` is low.
- R3: The first edge of an enable period loads data and never raises a flag. A monitored bit whose value differs from the previous edge, at an edge where `lat_en` was also high on the previous edge, raises that bit's flag.
- R4: A bit whose `EDL_MASK` bit is 0 is a plain latch. Changes on it never produce an error.
- R5: A flag stays set for the rest of the open window, even if the data later returns to its first value.
- R6: The edge where `lat_en` is first seen low after being high clears all flags. One further low edge clears the group gates. A token that follows an errored token reports clean if it has no late change of its own.
- R7: Latches are grouped `PER_GRP` at a time, and groups are merged `GRP_PER_SMP` at a time. Slots left over in the last group or the last sampler are tied to no-error. A late change on any monitored bit, including bits in the last partial group, is reported.
- R8: At an edge where `sample` is high, the edge sets `err_hit` if any group gate is set and `err_clean` otherwise. A flag raised at edge k is seen by a sample taken at edge k+2. At an edge where `sample` is low, both rails go low.
- R9: `err_hit` and `err_clean` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d | input | N_LAT | Latch data inputs |
| lat_en | input | 1 | Latch enable; high opens the transparent/detection window |
| sample | input | 1 | Request to present the collected error verdict |
| q | output | N_LAT | Latched data |
| err_hit | output | 1 | Error rail: a timing error was recorded |
| err_clean | output | 1 | No-error rail: no timing error was recorded |

## Verification
A flag stuck high or a group gate that never clears shows up as a wrong rail on the very next sample, one cycle after `sample` rises. Because of this, each token pairs a late-change pattern with a sample and checks the rail against the expected value. Tokens that are clean directly after errored tokens expose state left over from the previous token. Changes on a plain latch and on the last partial group expose a wrong mask or wrong padding at the first sample after the change. A latch that fails to hold its data appears on `q` at the first edge with the enable low.

// File: rtl/edl_bank.sv
module edl_bank #(
  parameter int N_LAT       = 20,
  parameter int PER_GRP     = 3,
  parameter int GRP_PER_SMP = 4,
  parameter logic [N_LAT-1:0] EDL_MASK = 20'hFFFF7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LAT-1:0] d,
  input  logic             lat_en,
  input  logic             sample,
  output logic [N_LAT-1:0] q,
  output logic             err_hit,
  output logic             err_clean
);
  localparam int N_GRP   = (N_LAT + PER_GRP - 1) / PER_GRP;
  localparam int N_SMP   = (N_GRP + GRP_PER_SMP - 1) / GRP_PER_SMP;
  localparam int PAD_LAT = N_GRP * PER_GRP;
  localparam int PAD_GRP = N_SMP * GRP_PER_SMP;

  logic [N_LAT-1:0]   d_prev, flag;
  logic [PAD_LAT-1:0] flag_pad;
  logic [N_GRP-1:0]   grp;
  logic [PAD_GRP-1:0] grp_pad;
  logic [N_SMP-1:0]   smp_or;
  logic               en_q, window, closing, any_err;

  assign window  = lat_en & en_q;
  assign closing = ~lat_en & en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q      <= '0;
      d_prev <= '0;
      en_q   <= 1'b0;
    end else begin
      if (lat_en) q <= d;
      d_prev <= d;
      en_q   <= lat_en;
    end

  for (genvar i = 0; i < N_LAT; i++) begin : g_lat
    if (EDL_MASK[i]) begin : g_edl
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                          flag[i] <= 1'b0;
        else if (closing)                    flag[i] <= 1'b0;
        else if (window && d[i] != d_prev[i]) flag[i] <= 1'b1;
    end else begin : g_plain
      assign flag[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < PAD_LAT; i++) begin : g_fpad
    if (i < N_LAT) begin : g_real
      assign flag_pad[i] = flag[i];
    end else begin : g_tie
      assign flag_pad[i] = 1'b0;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_cel
    logic set_in;
    assign set_in = |flag_pad[g*PER_GRP +: PER_GRP];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       grp[g] <= 1'b0;
      else if (set_in)  grp[g] <= 1'b1;
      else if (!lat_en) grp[g] <= 1'b0;
  end

  for (genvar g = 0; g < PAD_GRP; g++) begin : g_gpad
    if (g < N_GRP) begin : g_real
      assign grp_pad[g] = grp[g];
    end else begin : g_tie
      assign grp_pad[g] = 1'b0;
    end
  end

  for (genvar s = 0; s < N_SMP; s++) begin : g_smp
    assign smp_or[s] = |grp_pad[s*GRP_PER_SMP +: GRP_PER_SMP];
  end

  assign any_err = |smp_or;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_hit   <= 1'b0;
      err_clean <= 1'b0;
    end else begin
      err_hit   <= sample & any_err;
      err_clean <= sample & ~any_err;
    end

  a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_hit && err_clean));

  a_r8_low_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> (!err_hit && !err_clean));

  a_r8_answer_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (err_hit || err_clean));

  a_r6_clear_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !lat_en) |=> (flag == '0));

  a_r2_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_en |=> (q == $past(q)));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lat_en |=> (!lat_en || ((flag & $past(flag)) == $past(flag))));

  a_r3_open_edge_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_en && flag == '0) |=> (flag == '0));
endmodule

// File: tb/tb_edl_bank.sv
module tb_edl_bank;
  localparam int N = 20;
  localparam logic [N-1:0] MASK = 20'hFFFF7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] d = '0;
  logic lat_en = 1'b0, sample = 1'b0;
  logic [N-1:0] q;
  logic err_hit, err_clean;

  int checks = 0, errors = 0;
  logic [N:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  edl_bank #(.N_LAT(N), .PER_GRP(3), .GRP_PER_SMP(4), .EDL_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .d(d), .lat_en(lat_en), .sample(sample),
    .q(q), .err_hit(err_hit), .err_clean(err_clean));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] v, input logic en, input logic s);
    @(negedge clk);
    d = v; lat_en = en; sample = s;
  endtask

  task automatic token(input string tag, input logic [N-1:0] v0,
                       input logic [N-1:0] v1, input logic [N-1:0] v2);
    logic e;
    e = |(((v0 ^ v1) | (v1 ^ v2)) & MASK);
    drive(v0, 1'b1, 1'b0);
    drive(v1, 1'b1, 1'b0);
    drive(v2, 1'b1, 1'b0);
    drive(v2, 1'b1, 1'b0);
    exp_q.push_back({e, v2});
    tag_q.push_back(tag);
    drive(v2, 1'b1, 1'b1);
    drive(v2, 1'b1, 1'b0);
    drive(v2, 1'b0, 1'b0);
    drive(v2, 1'b0, 1'b0);
    drive(v2, 1'b0, 1'b0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err_hit && err_clean) begin
        checks++; errors++;
        $display("FAIL R9: actual both rails high expected one-hot");
      end else if (err_hit || err_clean) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8: actual unexpected verdict %b%b expected none", err_hit, err_clean);
        end else begin
          logic [N:0] it;
          string t;
          it = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " verdict"}, {{(N-1){1'b0}}, err_hit}, {{(N-1){1'b0}}, it[N]});
          chk({t, " q"}, q, it[N-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 q reset", q, '0);
    chk("R1 rails reset", {{(N-2){1'b0}}, err_hit, err_clean}, '0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    token("R3 open edge loads clean", 20'hABCDE, 20'hABCDE, 20'hABCDE);
    token("R3 late change bit0", 20'h00000, 20'h00001, 20'h00001);
    token("R6 clean after error", 20'h00001, 20'h00001, 20'h00001);
    token("R4 plain latch ignored", 20'h00000, 20'h00008, 20'h00000);
    token("R5 sticky after revert", 20'h00000, 20'h00020, 20'h00000);
    token("R7 last partial group", 20'h00000, 20'h00000, 20'h80000);
    token("R7 middle group", 20'h12345, 20'h12345, 20'h12745);
    token("R2 pass-through clean", 20'hFFFFF, 20'hFFFFF, 20'hFFFFF);

    drive(20'h55555, 1'b0, 1'b0);
    drive(20'h0AAAA, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 hold when closed", q, 20'hFFFFF);

    exp_q.push_back({1'b0, 20'hFFFFF});
    tag_q.push_back("R8 sample with window closed");
    drive(20'h0AAAA, 1'b0, 1'b1);
    drive(20'h0AAAA, 1'b0, 1'b0);
    drive(20'h0AAAA, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 rails low after sample", {{(N-2){1'b0}}, err_hit, err_clean}, '0);

    repeat (3) @(posedge clk);
    chk("R8 every expected verdict seen", exp_q.size(), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule